// File: doc/BRIEF.md
# External Bus Request/Grant Controller

This block decides who owns a shared external memory port: the internal core or an outside bus master. The outside master raises an asynchronous request; once the port is quiet, the block answers with a grant and the master owns the port until it drops its request. Core accesses (reads or writes) are presented with a request line, a write flag and a flag that marks a read as the first of an atomic pair. Each access occupies the port for a fixed number of cycles and ends with a one-cycle acknowledge. The memory timing and data path sit elsewhere. Only ownership, stalling and the atomicity rules live here.

While the port is granted away, a core request is stalled at once, and one cycle later a hang indicator tells the outside master that the core is waiting. When the request is withdrawn, the grant and the hang indicator fall together, and the core's held access then runs. The grant is never moved while a core access is running. It is never given between the two reads of an atomic pair. It may be given between a paired read and a following write. An exclusive-use input keeps the port with the core for as long as the core keeps requesting. An outside request is still granted as soon as the core goes quiet. The arbitration runs on its own power-on reset, so it keeps serving the outside master while the system reset holds the core.

The controller is one state machine with five states. IDLE means the core owns the port and nothing is running. ACCESS means a core access is in flight. LOCKED means the first read of an atomic pair has ended and the port is held for the second access. GRANTED means the outside master owns the port. HANG means the port is granted away and the core is waiting. The transitions are:
- IDLE→GRANTED on a synchronized outside request, unless exclusive mode is on and the core is requesting.
- IDLE→ACCESS on a core request.
- ACCESS→LOCKED at the end of a paired read.
- ACCESS→IDLE at the end of any other access, or on system reset.
- LOCKED→ACCESS for the second read, or for a write when no grant may be given.
- LOCKED→GRANTED for a write when a grant may be given.
- LOCKED→IDLE on system reset.
- GRANTED→HANG on a core request.
- HANG→GRANTED when the core request is withdrawn.
- GRANTED→IDLE and HANG→IDLE when the outside request falls.

Top module: `ext_bus_arbiter`

## Requirements
- R1: The outside request passes through a two-flop synchronizer. If the request is driven high before clock edge k while the port is idle, the grant output is high after edge k+2 and still low after edge k+1.
- R2: While the grant is high, a core request makes core_stall_o high in the same cycle, and no acknowledge is given.
- R3: When a read flagged as first of a pair ends, the grant stays low through the following read, even if the outside request is already synchronized. The second read's acknowledge comes ACC_CYCLES+1 cycles after the first one.
- R4: When a paired read is followed by a write while the outside request is synchronized (exclusive mode off), the grant rises two cycles after the read's acknowledge, before the write runs.
- R5: With excl_i high, no grant is given while the core keeps requesting. Once the core request falls, the grant rises on the second following edge.
- R6: When the outside request is driven low, the grant falls after the third edge. A held core access then starts and is acknowledged after a further ACC_CYCLES edges.
- R7: While sys_rst_i is high, core requests are ignored (no acknowledge, no stall, no hang), and the outside request is granted with R1 timing.
- R8: grant_hang_o rises one edge after a core request meets a held grant. It stays low while the port is granted with no core request. It falls in the same cycle as the grant.
- R9: An outside request that is synchronized while a core access is in flight is not granted before that access is acknowledged. The grant rises two edges after the acknowledge once the core request is gone.
- R10: A core request accepted from IDLE is acknowledged (core_ack_o high for one cycle) after exactly ACC_CYCLES rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, active low; resets the arbitration |
| sys_rst_i | input | 1 | System reset, active high; holds the core side only |
| ext_req_i | input | 1 | Asynchronous bus request from the outside master |
| excl_i | input | 1 | Exclusive-use mode: the core keeps the port while it requests |
| core_req_i | input | 1 | Core access request, held until acknowledged |
| core_wr_i | input | 1 | 1 = write, 0 = read |
| core_pair_i | input | 1 | 1 = this read is the first of an atomic read pair |
| ext_grant_o | output | 1 | Bus grant to the outside master |
| grant_hang_o | output | 1 | Core is waiting on a granted-away port |
| core_stall_o | output | 1 | Core request held off by the grant |
| core_ack_o | output | 1 | One-cycle end-of-access acknowledge |

## Verification
The main function is tried with the outside request arriving on an idle port, during an access, during a paired read followed by a second read, and during a paired read followed by a write. These four patterns separate a grant that waits correctly from one that breaks an access or splits an atomic pair. The same request is repeated with the core streaming back-to-back accesses in exclusive mode. This shows that the grant is deferred rather than lost. Stall-then-release sequences and requests under system reset show that the hang indicator and the resumed access are timed exactly, and that arbitration does not depend on the core side.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ACCESS  = 3'd1,
        ST_LOCKED  = 3'd2,
        ST_GRANTED = 3'd3,
        ST_HANG    = 3'd4
    } arb_state_e;
endpackage

// File: rtl/arb_br_sync.sv
module arb_br_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/arb_access_timer.sv
module arb_access_timer #(
    parameter int ACC_CYCLES = 3
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic run_i,
    output logic last_o
);
    localparam int CW = $clog2(ACC_CYCLES + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(ACC_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cnt_q <= '0;
        end else if (!run_i || last_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = run_i && (cnt_q == LAST_CNT);
endmodule

// File: rtl/arb_port_fsm.sv
module arb_port_fsm
    import arb_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic sys_rst_i,
    input  logic br_sync_i,
    input  logic excl_i,
    input  logic core_req_i,
    input  logic core_wr_i,
    input  logic core_pair_i,
    input  logic acc_last_i,
    output logic acc_run_o,
    output logic ext_grant_o,
    output logic grant_hang_o,
    output logic core_stall_o,
    output logic core_ack_o
);
    arb_state_e state_q, state_d;
    logic       pair_open_q;
    logic       req_eff;

    // the core side is held quiet during system reset
    assign req_eff = core_req_i && !sys_rst_i;

    // state register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q     <= ST_IDLE;
            pair_open_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_ACCESS && state_q != ST_ACCESS) begin
                pair_open_q <= !core_wr_i && core_pair_i;
            end
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (br_sync_i && !(excl_i && req_eff)) begin
                    state_d = ST_GRANTED;
                end else if (req_eff) begin
                    state_d = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (sys_rst_i) begin
                    state_d = ST_IDLE;
                end else if (acc_last_i) begin
                    state_d = pair_open_q ? ST_LOCKED : ST_IDLE;
                end
            end
            ST_LOCKED: begin
                if (sys_rst_i) begin
                    state_d = ST_IDLE;
                end else if (req_eff && !core_wr_i) begin
                    state_d = ST_ACCESS;
                end else if (req_eff) begin
                    state_d = (br_sync_i && !excl_i) ? ST_GRANTED : ST_ACCESS;
                end
            end
            ST_GRANTED: begin
                if (!br_sync_i) begin
                    state_d = ST_IDLE;
                end else if (req_eff) begin
                    state_d = ST_HANG;
                end
            end
            ST_HANG: begin
                if (!br_sync_i) begin
                    state_d = ST_IDLE;
                end else if (!req_eff) begin
                    state_d = ST_GRANTED;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        acc_run_o    = (state_q == ST_ACCESS);
        ext_grant_o  = (state_q == ST_GRANTED) || (state_q == ST_HANG);
        grant_hang_o = (state_q == ST_HANG);
        core_stall_o = req_eff && ext_grant_o;
        core_ack_o   = (state_q == ST_ACCESS) && acc_last_i && !sys_rst_i;
    end

    // grant only rises after a synchronized request
    assert_grant_after_req_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(ext_grant_o) |-> $past(br_sync_i));

    // no acknowledge while the port is granted away
    assert_no_ack_granted_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ext_grant_o |-> !core_ack_o);

    // a closed pair window never turns straight into a grant on a read
    assert_pair_no_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_LOCKED && req_eff && !core_wr_i) |=> !ext_grant_o);

    // exclusive mode keeps the port while the core requests
    assert_excl_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (excl_i && req_eff && !ext_grant_o) |=> !ext_grant_o);

    // dropped request releases the grant on the next edge
    assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ext_grant_o && !br_sync_i) |=> !ext_grant_o);

    // hang needs a waiting core and falls with the grant
    assert_hang_needs_core_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        grant_hang_o |-> $past(req_eff));
    assert_hang_with_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(ext_grant_o) |-> !grant_hang_o);

    // grant never rises while an access is counting
    assert_no_grant_mid_access_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (acc_run_o && !acc_last_i && !sys_rst_i) |=> !ext_grant_o);
endmodule

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter #(
    parameter int SYNC_STAGES = 2,
    parameter int ACC_CYCLES  = 3
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic sys_rst_i,
    input  logic ext_req_i,
    input  logic excl_i,
    input  logic core_req_i,
    input  logic core_wr_i,
    input  logic core_pair_i,
    output logic ext_grant_o,
    output logic grant_hang_o,
    output logic core_stall_o,
    output logic core_ack_o
);
    logic br_sync;
    logic acc_run;
    logic acc_last;

    arb_br_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (por_n_i),
        .async_i (ext_req_i),
        .sync_o  (br_sync)
    );

    arb_access_timer #(.ACC_CYCLES(ACC_CYCLES)) u_timer (
        .clk_i   (clk_i),
        .rst_n_i (por_n_i),
        .run_i   (acc_run),
        .last_o  (acc_last)
    );

    arb_port_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_n_i      (por_n_i),
        .sys_rst_i    (sys_rst_i),
        .br_sync_i    (br_sync),
        .excl_i       (excl_i),
        .core_req_i   (core_req_i),
        .core_wr_i    (core_wr_i),
        .core_pair_i  (core_pair_i),
        .acc_last_i   (acc_last),
        .acc_run_o    (acc_run),
        .ext_grant_o  (ext_grant_o),
        .grant_hang_o (grant_hang_o),
        .core_stall_o (core_stall_o),
        .core_ack_o   (core_ack_o)
    );
endmodule

// File: tb/ext_bus_arbiter_tb.sv
module ext_bus_arbiter_tb;
    localparam int ACC = 3;

    logic clk = 1'b0;
    logic por_n, sys_rst, ext_req, excl, core_req, core_wr, core_pair;
    logic grant, hang, stall, ack;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #5 clk = ~clk;

    ext_bus_arbiter #(.SYNC_STAGES(2), .ACC_CYCLES(ACC)) u_dut (
        .clk_i        (clk),
        .por_n_i      (por_n),
        .sys_rst_i    (sys_rst),
        .ext_req_i    (ext_req),
        .excl_i       (excl),
        .core_req_i   (core_req),
        .core_wr_i    (core_wr),
        .core_pair_i  (core_pair),
        .ext_grant_o  (grant),
        .grant_hang_o (hang),
        .core_stall_o (stall),
        .core_ack_o   (ack)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // waits for the acknowledge; reports edges taken and whether grant was seen
    task automatic wait_ack(output int n, output bit bg_seen);
        n = 0;
        bg_seen = 1'b0;
        do begin
            tick(1);
            n++;
            bg_seen |= grant;
        end while (!ack && n < 40);
    endtask

    task automatic release_req(input string tag);
        ext_req = 1'b0;
        tick(2);
        chk(grant == 1'b1, {tag, " grant held during sync"}, int'(grant), 1);
        tick(1);
        chk(grant == 1'b0, {tag, " grant released"}, int'(grant), 0);
        chk(hang == 1'b0, {tag, " hang cleared with grant"}, int'(hang), 0);
    endtask

    task automatic t_reset();
        chk(grant == 1'b0, "reset grant", int'(grant), 0);
        chk(hang == 1'b0, "reset hang", int'(hang), 0);
        chk(stall == 1'b0, "reset stall", int'(stall), 0);
        chk(ack == 1'b0, "reset ack", int'(ack), 0);
    endtask

    task automatic t_grant_latency();
        ext_req = 1'b1;
        tick(2);
        chk(grant == 1'b0, "R1 grant not before sync", int'(grant), 0);
        tick(1);
        chk(grant == 1'b1, "R1 grant after sync", int'(grant), 1);
        tick(2);
        chk(hang == 1'b0, "R8 no hang without core", int'(hang), 0);
        release_req("R6 idle");
    endtask

    task automatic t_access_timing();
        int n;
        bit bg;
        core_req = 1'b1;
        core_wr  = 1'b1;
        wait_ack(n, bg);
        chk(n == ACC, "R10 ack latency", n, ACC);
        core_req = 1'b0;
        core_wr  = 1'b0;
        tick(1);
        chk(ack == 1'b0, "R10 ack single cycle", int'(ack), 0);
    endtask

    task automatic t_stall_release();
        int n;
        bit bg;
        ext_req = 1'b1;
        tick(3);
        chk(grant == 1'b1, "R2 grant up", int'(grant), 1);
        core_req = 1'b1;
        #1;
        chk(stall == 1'b1, "R2 stall same cycle", int'(stall), 1);
        chk(hang == 1'b0, "R8 hang not yet", int'(hang), 0);
        tick(1);
        chk(hang == 1'b1, "R8 hang one edge later", int'(hang), 1);
        tick(3);
        chk(ack == 1'b0, "R2 no ack while granted", int'(ack), 0);
        chk(hang == 1'b1, "R8 hang held", int'(hang), 1);
        release_req("R8 hang");
        chk(stall == 1'b0, "R6 stall cleared", int'(stall), 0);
        wait_ack(n, bg);
        chk(n == ACC, "R6 resumed access ack", n, ACC);
        core_req = 1'b0;
        tick(1);
    endtask

    task automatic t_mid_access();
        int n;
        bit bg;
        core_req = 1'b1;
        ext_req  = 1'b1;
        wait_ack(n, bg);
        chk(n == ACC, "R9 access completes", n, ACC);
        chk(bg == 1'b0, "R9 no grant mid access", int'(bg), 0);
        core_req = 1'b0;
        tick(1);
        chk(grant == 1'b0, "R9 grant waits one edge", int'(grant), 0);
        tick(1);
        chk(grant == 1'b1, "R9 grant after access", int'(grant), 1);
        release_req("R9");
    endtask

    task automatic t_read_pair();
        int n;
        bit bg;
        core_req  = 1'b1;
        core_pair = 1'b1;
        ext_req   = 1'b1;
        wait_ack(n, bg);
        chk(n == ACC, "R3 first read", n, ACC);
        core_pair = 1'b0;
        wait_ack(n, bg);
        chk(n == ACC + 1, "R3 second read latency", n, ACC + 1);
        chk(bg == 1'b0, "R3 no grant between reads", int'(bg), 0);
        core_req = 1'b0;
        tick(1);
        chk(grant == 1'b0, "R3 grant after pair wait", int'(grant), 0);
        tick(1);
        chk(grant == 1'b1, "R3 grant after pair", int'(grant), 1);
        release_req("R3");
    endtask

    task automatic t_read_write();
        int n;
        bit bg;
        core_req  = 1'b1;
        core_pair = 1'b1;
        ext_req   = 1'b1;
        wait_ack(n, bg);
        chk(n == ACC, "R4 paired read", n, ACC);
        core_pair = 1'b0;
        core_wr   = 1'b1;
        tick(1);
        chk(grant == 1'b0, "R4 grant not yet", int'(grant), 0);
        tick(1);
        chk(grant == 1'b1, "R4 grant before write", int'(grant), 1);
        chk(stall == 1'b1, "R4 write stalled", int'(stall), 1);
        tick(1);
        chk(hang == 1'b1, "R4 hang on write", int'(hang), 1);
        release_req("R4");
        wait_ack(n, bg);
        chk(n == ACC, "R4 write after release", n, ACC);
        core_req = 1'b0;
        core_wr  = 1'b0;
        tick(1);
    endtask

    task automatic t_exclusive();
        int n;
        bit bg;
        excl     = 1'b1;
        core_req = 1'b1;
        ext_req  = 1'b1;
        wait_ack(n, bg);
        chk(n == ACC && !bg, "R5 first exclusive access", n, ACC);
        for (int i = 0; i < 2; i++) begin
            wait_ack(n, bg);
            chk(n == ACC + 1, "R5 back-to-back latency", n, ACC + 1);
            chk(bg == 1'b0, "R5 no grant in exclusive", int'(bg), 0);
        end
        core_req = 1'b0;
        tick(1);
        chk(grant == 1'b0, "R5 grant one edge later", int'(grant), 0);
        tick(1);
        chk(grant == 1'b1, "R5 request serviced when idle", int'(grant), 1);
        release_req("R5");
        excl = 1'b0;
    endtask

    task automatic t_sys_rst();
        bit any_ack = 1'b0;
        sys_rst  = 1'b1;
        core_req = 1'b1;
        for (int i = 0; i < ACC + 2; i++) begin
            tick(1);
            any_ack |= ack;
        end
        chk(any_ack == 1'b0, "R7 core ignored in reset", int'(any_ack), 0);
        ext_req = 1'b1;
        tick(2);
        chk(grant == 1'b0, "R7 sync in reset", int'(grant), 0);
        tick(1);
        chk(grant == 1'b1, "R7 grant in reset", int'(grant), 1);
        chk(stall == 1'b0, "R7 no stall in reset", int'(stall), 0);
        tick(1);
        chk(hang == 1'b0, "R7 no hang in reset", int'(hang), 0);
        release_req("R7");
        core_req = 1'b0;
        sys_rst  = 1'b0;
        tick(1);
    endtask

    initial begin
        por_n = 1'b0; sys_rst = 1'b0; ext_req = 1'b0; excl = 1'b0;
        core_req = 1'b0; core_wr = 1'b0; core_pair = 1'b0;
        tick(3);
        por_n = 1'b1;
        tick(1);
        t_reset();
        t_grant_latency();
        t_access_timing();
        t_stall_release();
        t_mid_access();
        t_read_pair();
        t_read_write();
        t_exclusive();
        t_sys_rst();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule